// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte Writes

A synchronous single-port memory for second-level cache duty. Every input (address, write controls, chip selects, write data) is captured by an input register on the rising clock edge. A captured write updates the array on the following edge. A captured read goes through a second register stage before it reaches the output. The word is 32 bits, split into four 8-bit lanes. A write can cover the whole word through one global control, or only selected lanes through a qualifier combined with per-lane enables.

Three chip selects let several instances share one data bus for depth expansion. Turning a device's output on takes two clock cycles, while turning it off takes one, so a device that is being released stops driving before a newly selected one starts. The output enable gates the read data bus asynchronously. A sleep input freezes all activity at once: the contents are kept, and no read or write takes place while it is held.

The depth is 2^ADDR_W words. The full-size part uses ADDR_W = 16; the default is smaller to keep elaboration light.

Top module: `sync_sram`

## Requirements
- R1: The array holds 2^ADDR_W words of 32 bits in four lanes. Lane 0 is bits [7:0], lane 1 is [15:8], lane 2 is [23:16] and lane 3 is [31:24]. Lane l is governed by lane_wr_ni[l].
- R2: When full_wr_ni is low in a selected cycle, the whole word at the address is written, whatever byte_wr_ni and lane_wr_ni hold.
- R3: When full_wr_ni is high, lane l is written only if byte_wr_ni is low and lane_wr_ni[l] is low. If byte_wr_ni is high, or no lane enable is low, the cycle is a read and nothing is written.
- R4: Read latency is two cycles. A read sampled at edge k shows its data on rdata_o, with rvalid_o high, after edge k+1. That data lasts for one cycle per read.
- R5: out_en_ni acts without the clock. While it is high, rdata_o is zero. rvalid_o does not depend on it.
- R6: The device is selected only when cs_a_ni is low, cs_b_i is high and cs_c_ni is low. A cycle sampled while it is unselected neither reads nor writes.
- R7: After an edge that samples the device unselected, rvalid_o is low in the very next cycle, even for a read issued one cycle earlier. After the first selected edge that follows, rvalid_o stays low for one more cycle.
- R8: While sleep_i is high, rvalid_o and rdata_o are low at once, no command is sampled, and the array keeps its contents.
- R9: Write data is captured together with its write command. A read of the same address in the next cycle returns the new data.
- R10: While rst_ni is low, rvalid_o and rdata_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Power-down, active high |
| addr_i | input | ADDR_W | Word address |
| full_wr_ni | input | 1 | Whole-word write, active low |
| byte_wr_ni | input | 1 | Lane write qualifier, active low |
| lane_wr_ni | input | 4 | Per-lane write enables, active low |
| cs_a_ni | input | 1 | Chip select, active low |
| cs_b_i | input | 1 | Chip select, active high |
| cs_c_ni | input | 1 | Chip select, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not driven |
| rvalid_o | output | 1 | Read data valid |

## Verification
Three write patterns separate the controls from one another. The first is a global write with every lane enable inactive, which shows that the global control wins. The second is a qualified write with a sparse lane pattern, which exposes lane ordering and bit positions. The third has the lane enables low but the qualifier off, which must leave the word untouched. The bench alternates between two addresses holding different contents, which pins the read latency to exactly two edges and shows that a read is valid for one cycle only. Write attempts are made with each single chip select wrong, and a read is placed just before a deselect, which confirms the one-cycle release and the two-cycle turn-on. Sleep and the output enable are toggled between clock edges to show that they act without the clock.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;
  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sram_in_reg.sv
`timescale 1ns/1ps
module sram_in_reg
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              full_wr_ni,
  input  logic              byte_wr_ni,
  input  lane_mask_t        lane_wr_ni,
  input  logic              sel_i,
  input  word_t             wdata_i,
  output logic              sel_q_o,
  output logic              rd_q_o,
  output logic              wr_q_o,
  output lane_mask_t        mask_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output word_t             wdata_q_o
);
  logic       go;
  lane_mask_t mask_in;
  logic       wr_in;

  assign go      = sel_i & ~sleep_i;
  // global write overrides lane enables; lanes need the qualifier
  assign mask_in = !full_wr_ni ? '1 : (!byte_wr_ni ? ~lane_wr_ni : '0);
  assign wr_in   = go & (|mask_in);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q_o   <= 1'b0;
      rd_q_o    <= 1'b0;
      wr_q_o    <= 1'b0;
      mask_q_o  <= '0;
      addr_q_o  <= '0;
      wdata_q_o <= '0;
    end else begin
      sel_q_o  <= go;
      rd_q_o   <= go & ~wr_in;
      wr_q_o   <= wr_in;
      mask_q_o <= wr_in ? mask_in : '0;
      if (go) begin
        addr_q_o  <= addr_i;
        wdata_q_o <= wdata_i;
      end
    end
  end

  AST_FULL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !sleep_i && !full_wr_ni) |=> (wr_q_o && mask_q_o == '1)); // R2
  AST_NEED_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_wr_ni && byte_wr_ni) |=> (!wr_q_o && mask_q_o == '0)); // R3
  AST_SLEEP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!wr_q_o && !rd_q_o)); // R8
  AST_UNSEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (!wr_q_o && !rd_q_o && !sel_q_o)); // R6
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  lane_mask_t        mask_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  output word_t             rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_i && mask_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_out_reg.sv
`timescale 1ns/1ps
module sram_out_reg
  import sram_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sleep_i,
  input  logic  rd_i,
  input  word_t rdata_i,
  output logic  vld_q_o,
  output word_t data_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q_o  <= 1'b0;
      data_q_o <= '0;
    end else begin
      vld_q_o <= rd_i & ~sleep_i;
      if (rd_i) data_q_o <= rdata_i;
    end
  end

  AST_VLD_FROM_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q_o |-> $past(rd_i)); // R4
endmodule

// File: rtl/sync_sram.sv
`timescale 1ns/1ps
module sync_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              full_wr_ni,
  input  logic              byte_wr_ni,
  input  logic [3:0]        lane_wr_ni,
  input  logic              cs_a_ni,
  input  logic              cs_b_i,
  input  logic              cs_c_ni,
  input  logic              out_en_ni,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  logic              sel_in, sel_q, rd_q, wr_q, vld_q;
  lane_mask_t        mask_q;
  logic [ADDR_W-1:0] addr_q;
  word_t             wdata_q, arr_rdata, data_q;

  assign sel_in = ~cs_a_ni & cs_b_i & ~cs_c_ni;

  sram_in_reg #(.ADDR_W(ADDR_W)) i_in_reg (
    .clk_i, .rst_ni, .sleep_i, .addr_i, .full_wr_ni, .byte_wr_ni, .lane_wr_ni,
    .sel_i(sel_in), .wdata_i,
    .sel_q_o(sel_q), .rd_q_o(rd_q), .wr_q_o(wr_q), .mask_q_o(mask_q),
    .addr_q_o(addr_q), .wdata_q_o(wdata_q)
  );

  sram_array #(.ADDR_W(ADDR_W)) i_array (
    .clk_i, .wr_i(wr_q), .mask_i(mask_q), .addr_i(addr_q),
    .wdata_i(wdata_q), .rdata_o(arr_rdata)
  );

  sram_out_reg i_out_reg (
    .clk_i, .rst_ni, .sleep_i, .rd_i(rd_q), .rdata_i(arr_rdata),
    .vld_q_o(vld_q), .data_q_o(data_q)
  );

  // release after one edge (sel_q), turn-on after two (vld_q)
  assign rvalid_o = vld_q & sel_q & ~sleep_i;
  assign rdata_o  = (rvalid_o && !out_en_ni) ? data_q : '0;

  AST_DESEL_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_in |=> !rvalid_o); // R7
  AST_SEL_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(sel_in, 2) && $past(sel_in))); // R7
  AST_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0)); // R5
endmodule

// File: tb/test_sync_sram.sv
`timescale 1ns/1ps
module test_sync_sram;
  localparam int unsigned ADDR_W = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sleep_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              full_wr_ni = 1'b1;
  logic              byte_wr_ni = 1'b1;
  logic [3:0]        lane_wr_ni = 4'hF;
  logic              cs_a_ni = 1'b0;
  logic              cs_b_i = 1'b1;
  logic              cs_c_ni = 1'b0;
  logic              out_en_ni = 1'b0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              rvalid_o;

  int checks = 0;
  int errors = 0;
  logic [ADDR_W-1:0] idle_addr = '0;

  always #10 clk_i = ~clk_i;

  sync_sram #(.ADDR_W(ADDR_W)) i_sync_sram (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    addr_i = idle_addr; full_wr_ni = 1'b1; byte_wr_ni = 1'b1; lane_wr_ni = 4'hF;
    cs_a_ni = 1'b0; cs_b_i = 1'b1; cs_c_ni = 1'b0; wdata_i = '0;
  endtask

  task automatic drive_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          input logic fn, input logic bn, input logic [3:0] ln);
    addr_i = a; wdata_i = d; full_wr_ni = fn; byte_wr_ni = bn; lane_wr_ni = ln;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                    input logic fn, input logic bn, input logic [3:0] ln);
    drive_wr(a, d, fn, bn, ln);
    @(negedge clk_i); idle();
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    addr_i = a;
    @(negedge clk_i); idle();
    @(negedge clk_i);
    chk(req, {31'd0, rvalid_o}, 32'd1);
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk("R10 valid", {31'd0, rvalid_o}, 32'd0);
    chk("R10 data", rdata_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_full();
    wr(10, 32'hA1B2C3D4, 1'b0, 1'b1, 4'hF);
    rd_chk("R2 full over lanes", 10, 32'hA1B2C3D4);
  endtask

  task automatic t_bytes();
    wr(20, 32'h0, 1'b0, 1'b1, 4'hF);
    wr(20, 32'hDEADBEEF, 1'b1, 1'b0, 4'b1010);
    rd_chk("R3 lanes 0,2", 20, 32'h00AD00EF);
    wr(20, 32'hFFFFFFFF, 1'b1, 1'b1, 4'h0);
    rd_chk("R3 no qualifier", 20, 32'h00AD00EF);
    wr(20, 32'h77665544, 1'b1, 1'b0, 4'b0111);
    rd_chk("R1 lane 3 position", 20, 32'h77AD00EF);
  endtask

  task automatic t_latency();
    wr(30, 32'h30303030, 1'b0, 1'b1, 4'hF);
    wr(31, 32'h31313131, 1'b0, 1'b1, 4'hF);
    idle_addr = 30; idle();
    repeat (2) @(negedge clk_i);
    addr_i = 31;
    @(negedge clk_i); idle();
    chk("R4 not yet", rdata_o, 32'h30303030);
    @(negedge clk_i);
    chk("R4 two edges", rdata_o, 32'h31313131);
    @(negedge clk_i);
    chk("R4 one cycle", rdata_o, 32'h30303030);
  endtask

  task automatic t_oe();
    out_en_ni = 1'b1; #1;
    chk("R5 data off", rdata_o, 32'd0);
    chk("R5 valid kept", {31'd0, rvalid_o}, 32'd1);
    out_en_ni = 1'b0; #1;
    chk("R5 data back", rdata_o, 32'h30303030);
    @(negedge clk_i);
  endtask

  task automatic t_cs_ignore();
    wr(40, 32'h40404040, 1'b0, 1'b1, 4'hF);
    for (int i = 0; i < 3; i++) begin
      drive_wr(40, 32'hBAD00000 + i, 1'b0, 1'b1, 4'hF);
      if (i == 0) cs_a_ni = 1'b1;
      if (i == 1) cs_b_i = 1'b0;
      if (i == 2) cs_c_ni = 1'b1;
      @(negedge clk_i); idle();
    end
    rd_chk("R6 unselected write", 40, 32'h40404040);
  endtask

  task automatic t_cs_timing();
    addr_i = 31;
    @(negedge clk_i);
    cs_b_i = 1'b0;
    @(negedge clk_i);
    chk("R7 release one cycle", {31'd0, rvalid_o}, 32'd0);
    idle();
    @(negedge clk_i);
    chk("R7 turn-on not yet", {31'd0, rvalid_o}, 32'd0);
    @(negedge clk_i);
    chk("R7 turn-on two", {31'd0, rvalid_o}, 32'd1);
  endtask

  task automatic t_sleep();
    sleep_i = 1'b1; #1;
    chk("R8 valid off", {31'd0, rvalid_o}, 32'd0);
    chk("R8 data off", rdata_o, 32'd0);
    @(negedge clk_i);
    drive_wr(30, 32'h0BADBAD0, 1'b0, 1'b1, 4'hF);
    @(negedge clk_i); idle();
    @(negedge clk_i);
    chk("R8 still off", {31'd0, rvalid_o}, 32'd0);
    sleep_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rd_chk("R8 contents kept", 30, 32'h30303030);
  endtask

  task automatic t_raw();
    wr(50, 32'h55555555, 1'b0, 1'b1, 4'hF);
    drive_wr(50, 32'hC0FFEE01, 1'b0, 1'b1, 4'hF);
    @(negedge clk_i); idle(); addr_i = 50;
    @(negedge clk_i); idle();
    @(negedge clk_i);
    chk("R9 read after write", rdata_o, 32'hC0FFEE01);
  endtask

  initial begin
    t_reset();
    t_full();
    t_bytes();
    t_latency();
    t_oe();
    t_cs_ignore();
    t_cs_timing();
    t_sleep();
    t_raw();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule